// File: doc/BRIEF.md
# Video demo mode controller

This block is the control plane of a two-mode video test design. In transmit mode a separate timing generator produces test video. The block supplies that generator with a format index from 0 to 5. The six formats are 640x480, 720x480, 1024x768, 1280x1024, 1920x1080 and 1600x1200, all progressive at 60 Hz, with pixel clocks of 25, 27, 65, 108, 148.5 and 162 MHz. In loopback mode the video arriving from the receiver goes straight back out to the transmitter. A registered source multiplexer inside the block chooses between the two streams. It carries the pixel word, both syncs and data enable.

Three active-low push buttons drive the block. Each button is synchronised and debounced, and becomes a one-cycle press pulse. The buttons toggle the mode, advance the format index and launch a rewrite of the display-identification EEPROM. The block does not write the EEPROM itself. It sends a start pulse to an external writer and watches that writer's busy, done and fail lines. Four LEDs show the state: the mode, the index, or a common blink while the rewrite is running.

The video path is a timed stream with no back-pressure. Data enable qualifies each pixel word, as a valid would, and there is no ready. A sink must accept every cycle. The output is the selected input delayed by exactly one clock.

Top module: `video_demo_ctrl`

## Requirements
- R1: A button input must hold its new level for DEBOUNCE_CYCLES consecutive clocks before it counts. A low pulse shorter than that changes no output.
- R2: A press acts exactly once, when the debounced level falls (button pressed). Holding the button for any length of time, and releasing it, causes no further action.
- R3: After reset the block is in transmit mode (`loop_mode`=0, `src_sel`=0). Each accepted press of the mode button inverts `loop_mode`, and `src_sel` follows it (1 = receiver).
- R4: `pattern_idx` resets to 0. Each accepted press of the pattern button in transmit mode adds one to it, and 5 is followed by 0.
- R5: In loopback mode, presses of the pattern button are ignored and `pattern_idx` keeps its value.
- R6: In transmit mode, with no rewrite in progress, `led[3]` is 0 and `led[2:0]` equals `pattern_idx` in binary.
- R7: In loopback mode, with no rewrite in progress, `led` is 4'b1111.
- R8: `tx_data`, `tx_hs`, `tx_vs` and `tx_de` take, one clock later, the receiver inputs when `src_sel`=1 and the generator inputs when `src_sel`=0. They are all 0 after reset.
- R9: When the rewrite button is pressed, `edid_busy` is low and no rewrite is in progress, `edid_start` goes high for exactly one cycle. Otherwise the press is ignored.
- R10: A rewrite is in progress from the `edid_start` pulse onward. During it all four LEDs show the same value. They are lit for BLINK_HALF_CYCLES clocks starting with the cycle of the start pulse, then dark for the same length, and so on.
- R11: A one-cycle `edid_done` or `edid_fail` ends the rewrite. The LEDs then return to the R6/R7 display, and a later rewrite press issues a new start pulse.
- R12: While a rewrite is in progress, presses of the mode and pattern buttons are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for control and video |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_mode_n | input | 1 | Mode button, low when pressed |
| btn_pattern_n | input | 1 | Format-advance button, low when pressed |
| btn_edid_n | input | 1 | EEPROM rewrite button, low when pressed |
| edid_busy | input | 1 | Writer is working |
| edid_done | input | 1 | Writer finished successfully (one-cycle pulse) |
| edid_fail | input | 1 | Writer gave up (one-cycle pulse) |
| edid_start | output | 1 | One-cycle request to the writer |
| loop_mode | output | 1 | 1 = loopback, 0 = transmit |
| pattern_idx | output | 3 | Format index for the timing generator |
| src_sel | output | 1 | Source-multiplexer select, 1 = receiver |
| led | output | 4 | Status LEDs |
| gen_data | input | 24 | Generator pixel word |
| gen_hs | input | 1 | Generator horizontal sync |
| gen_vs | input | 1 | Generator vertical sync |
| gen_de | input | 1 | Generator data enable |
| rx_data | input | 24 | Receiver pixel word |
| rx_hs | input | 1 | Receiver horizontal sync |
| rx_vs | input | 1 | Receiver vertical sync |
| rx_de | input | 1 | Receiver data enable |
| tx_data | output | 24 | Transmitter pixel word |
| tx_hs | output | 1 | Transmitter horizontal sync |
| tx_vs | output | 1 | Transmitter vertical sync |
| tx_de | output | 1 | Transmitter data enable |

## Verification
The bench sends a short low glitch on a button. A debouncer that is too short would treat it as a press. It holds the mode button for a long time to catch a controller that acts on release or repeats while the button is held. It steps the format index past 5 to catch a wrap to 6 or 7, and it presses the format button in loopback to catch an index that moves when it should not. During a rewrite it checks the blink phase at fixed offsets from the start pulse, presses every button, and then ends one rewrite with a failure and a second with success. A design that lets a press through while busy, never clears the busy state, or refuses a retry after a failure shows a wrong mode, a wrong index or a wrong count of start pulses.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

  // Which stream feeds the transmitter.
  typedef enum logic {
    SRC_PATTERN  = 1'b0,
    SRC_RECEIVER = 1'b1
  } vsrc_e;

  // Button slots inside the conditioner array.
  localparam int BTN_MODE    = 0;
  localparam int BTN_PATTERN = 1;
  localparam int BTN_EDID    = 2;
  localparam int NUM_BTNS    = 3;

endpackage

// File: rtl/btn_conditioner.sv
// Synchroniser, debouncer and press-edge detector for one active-low button.
module btn_conditioner #(
  parameter int STABLE_CYCLES = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n_i,
  output logic press_o
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [1:0]    sync_q;
  logic          level_q;   // debounced level, 1 = released
  logic [CW-1:0] cnt_q;
  logic          differs;
  logic          settle;

  assign differs = (sync_q[1] != level_q);
  assign settle  = differs && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], btn_n_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
      press_o <= 1'b0;
    end else begin
      press_o <= settle && !sync_q[1];
      if (!differs) begin
        cnt_q <= '0;
      end else if (settle) begin
        level_q <= sync_q[1];
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/blink_gen.sv
// Square wave for the LEDs. It restarts in the lit phase whenever it is disabled.
module blink_gen #(
  parameter int HALF_CYCLES = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic lit_o
);
  localparam int HW = $clog2(HALF_CYCLES + 1);
  localparam logic [HW-1:0] LAST = HW'(HALF_CYCLES - 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lit_o <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      lit_o <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      lit_o <= ~lit_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mode_ctrl.sv
// Mode, format index and EEPROM-rewrite handshake.
module mode_ctrl
  import vdc_pkg::*;
#(
  parameter int NUM_PATTERNS = 6,
  parameter int IDX_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             press_mode_i,
  input  logic             press_pat_i,
  input  logic             press_edid_i,
  input  logic             edid_busy_i,
  input  logic             edid_done_i,
  input  logic             edid_fail_i,
  output vsrc_e            src_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             init_busy_o,
  output logic             edid_start_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_PATTERNS - 1);

  logic [IDX_W-1:0] idx_next;
  logic             launch;

  assign idx_next = (idx_o == IDX_LAST) ? '0 : idx_o + 1'b1;
  assign launch   = press_edid_i && !edid_busy_i && !init_busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_o        <= SRC_PATTERN;
      idx_o        <= '0;
      init_busy_o  <= 1'b0;
      edid_start_o <= 1'b0;
    end else begin
      edid_start_o <= launch;
      if (init_busy_o) begin
        if (edid_done_i || edid_fail_i) begin
          init_busy_o <= 1'b0;
        end
      end else begin
        if (launch) begin
          init_busy_o <= 1'b1;
        end
        if (press_mode_i) begin
          src_o <= (src_o == SRC_PATTERN) ? SRC_RECEIVER : SRC_PATTERN;
        end
        if (press_pat_i && (src_o == SRC_PATTERN)) begin
          idx_o <= idx_next;
        end
      end
    end
  end
endmodule

// File: rtl/video_src_mux.sv
// Registered selection between generator and receiver video.
module video_src_mux
  import vdc_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vsrc_e            sel_i,
  input  logic [PIX_W-1:0] gen_data_i,
  input  logic             gen_hs_i,
  input  logic             gen_vs_i,
  input  logic             gen_de_i,
  input  logic [PIX_W-1:0] rx_data_i,
  input  logic             rx_hs_i,
  input  logic             rx_vs_i,
  input  logic             rx_de_i,
  output logic [PIX_W-1:0] tx_data_o,
  output logic             tx_hs_o,
  output logic             tx_vs_o,
  output logic             tx_de_o
);
  localparam int BW = PIX_W + 3;

  logic [BW-1:0] gen_bus, rx_bus, pick, out_q;

  assign gen_bus = {gen_data_i, gen_hs_i, gen_vs_i, gen_de_i};
  assign rx_bus  = {rx_data_i, rx_hs_i, rx_vs_i, rx_de_i};

  always_comb begin
    unique case (sel_i)
      SRC_RECEIVER: pick = rx_bus;
      default:      pick = gen_bus;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= pick;
  end

  assign {tx_data_o, tx_hs_o, tx_vs_o, tx_de_o} = out_q;
endmodule

// File: rtl/video_demo_ctrl.sv
module video_demo_ctrl
  import vdc_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES   = 500_000,
  parameter int BLINK_HALF_CYCLES = 12_500_000,
  parameter int NUM_PATTERNS      = 6,
  parameter int PIX_W             = 24,
  localparam int IDX_W            = $clog2(NUM_PATTERNS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_mode_n,
  input  logic             btn_pattern_n,
  input  logic             btn_edid_n,
  input  logic             edid_busy,
  input  logic             edid_done,
  input  logic             edid_fail,
  output logic             edid_start,
  output logic             loop_mode,
  output logic [IDX_W-1:0] pattern_idx,
  output logic             src_sel,
  output logic [IDX_W:0]   led,
  input  logic [PIX_W-1:0] gen_data,
  input  logic             gen_hs,
  input  logic             gen_vs,
  input  logic             gen_de,
  input  logic [PIX_W-1:0] rx_data,
  input  logic             rx_hs,
  input  logic             rx_vs,
  input  logic             rx_de,
  output logic [PIX_W-1:0] tx_data,
  output logic             tx_hs,
  output logic             tx_vs,
  output logic             tx_de
);
  localparam int LED_W = IDX_W + 1;

  logic [NUM_BTNS-1:0] btn_n, press;
  vsrc_e               src;
  logic                init_busy;
  logic                blink_lit;

  assign btn_n[BTN_MODE]    = btn_mode_n;
  assign btn_n[BTN_PATTERN] = btn_pattern_n;
  assign btn_n[BTN_EDID]    = btn_edid_n;

  for (genvar b = 0; b < NUM_BTNS; b++) begin : g_btn
    btn_conditioner #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .btn_n_i (btn_n[b]),
      .press_o (press[b])
    );
  end

  mode_ctrl #(.NUM_PATTERNS(NUM_PATTERNS), .IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .press_mode_i (press[BTN_MODE]),
    .press_pat_i  (press[BTN_PATTERN]),
    .press_edid_i (press[BTN_EDID]),
    .edid_busy_i  (edid_busy),
    .edid_done_i  (edid_done),
    .edid_fail_i  (edid_fail),
    .src_o        (src),
    .idx_o        (pattern_idx),
    .init_busy_o  (init_busy),
    .edid_start_o (edid_start)
  );

  blink_gen #(.HALF_CYCLES(BLINK_HALF_CYCLES)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (init_busy),
    .lit_o (blink_lit)
  );

  video_src_mux #(.PIX_W(PIX_W)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (src),
    .gen_data_i (gen_data),
    .gen_hs_i   (gen_hs),
    .gen_vs_i   (gen_vs),
    .gen_de_i   (gen_de),
    .rx_data_i  (rx_data),
    .rx_hs_i    (rx_hs),
    .rx_vs_i    (rx_vs),
    .rx_de_i    (rx_de),
    .tx_data_o  (tx_data),
    .tx_hs_o    (tx_hs),
    .tx_vs_o    (tx_vs),
    .tx_de_o    (tx_de)
  );

  assign loop_mode = (src == SRC_RECEIVER);
  assign src_sel   = (src == SRC_RECEIVER);

  always_comb begin
    if (init_busy)      led = {LED_W{blink_lit}};
    else if (loop_mode) led = '1;
    else                led = {1'b0, pattern_idx};
  end
endmodule

// File: rtl/video_demo_ctrl_chk.sv
module video_demo_ctrl_chk #(
  parameter int NUM_PATTERNS = 6,
  parameter int IDX_W        = 3,
  parameter int PIX_W        = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edid_start,
  input logic             edid_busy,
  input logic             init_busy,
  input logic             loop_mode,
  input logic             src_sel,
  input logic [IDX_W-1:0] pattern_idx,
  input logic [IDX_W:0]   led,
  input logic [PIX_W-1:0] gen_data,
  input logic             gen_hs,
  input logic             gen_vs,
  input logic             gen_de,
  input logic [PIX_W-1:0] rx_data,
  input logic             rx_hs,
  input logic             rx_vs,
  input logic             rx_de,
  input logic [PIX_W-1:0] tx_data,
  input logic             tx_hs,
  input logic             tx_vs,
  input logic             tx_de
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_PATTERNS - 1);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    edid_start |=> !edid_start); // R9

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && edid_start) |-> !$past(edid_busy)); // R9

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_idx <= IDX_LAST); // R4

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$stable(pattern_idx)) |->
      (pattern_idx == (($past(pattern_idx) == IDX_LAST) ? '0 : $past(pattern_idx) + 1'b1))); // R4

  AST_IDX_FROZEN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(loop_mode)) |-> $stable(pattern_idx)); // R5

  AST_CTRL_FROZEN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(init_busy)) |-> ($stable(loop_mode) && $stable(pattern_idx))); // R12

  AST_LOOP_LEDS: assert property (@(posedge clk) disable iff (!rst_n)
    loop_mode |-> (led == '0 || led == '1)); // R7

  AST_BLINK_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (led == '0 || led == '1)); // R10

  AST_MUX_RECEIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(src_sel)) |->
      ({tx_data, tx_hs, tx_vs, tx_de} == $past({rx_data, rx_hs, rx_vs, rx_de}))); // R8

  AST_MUX_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(src_sel)) |->
      ({tx_data, tx_hs, tx_vs, tx_de} == $past({gen_data, gen_hs, gen_vs, gen_de}))); // R8
endmodule

bind video_demo_ctrl video_demo_ctrl_chk #(
  .NUM_PATTERNS (NUM_PATTERNS),
  .IDX_W        (IDX_W),
  .PIX_W        (PIX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .edid_start  (edid_start),
  .edid_busy   (edid_busy),
  .init_busy   (init_busy),
  .loop_mode   (loop_mode),
  .src_sel     (src_sel),
  .pattern_idx (pattern_idx),
  .led         (led),
  .gen_data    (gen_data),
  .gen_hs      (gen_hs),
  .gen_vs      (gen_vs),
  .gen_de      (gen_de),
  .rx_data     (rx_data),
  .rx_hs       (rx_hs),
  .rx_vs       (rx_vs),
  .rx_de       (rx_de),
  .tx_data     (tx_data),
  .tx_hs       (tx_hs),
  .tx_vs       (tx_vs),
  .tx_de       (tx_de)
);

// File: tb/video_demo_ctrl_test.sv
module video_demo_ctrl_test;
  localparam int DB   = 16;
  localparam int HALF = 40;
  localparam int PW   = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rst_n;
  logic          btn_mode_n, btn_pattern_n, btn_edid_n;
  logic          edid_busy, edid_done, edid_fail, edid_start;
  logic          loop_mode, src_sel;
  logic [2:0]    pattern_idx;
  logic [3:0]    led;
  logic [PW-1:0] gen_data, rx_data, tx_data;
  logic          gen_hs, gen_vs, gen_de, rx_hs, rx_vs, rx_de, tx_hs, tx_vs, tx_de;

  video_demo_ctrl #(.DEBOUNCE_CYCLES(DB), .BLINK_HALF_CYCLES(HALF)) uut (
    .clk(clk), .rst_n(rst_n),
    .btn_mode_n(btn_mode_n), .btn_pattern_n(btn_pattern_n), .btn_edid_n(btn_edid_n),
    .edid_busy(edid_busy), .edid_done(edid_done), .edid_fail(edid_fail),
    .edid_start(edid_start), .loop_mode(loop_mode), .pattern_idx(pattern_idx),
    .src_sel(src_sel), .led(led),
    .gen_data(gen_data), .gen_hs(gen_hs), .gen_vs(gen_vs), .gen_de(gen_de),
    .rx_data(rx_data), .rx_hs(rx_hs), .rx_vs(rx_vs), .rx_de(rx_de),
    .tx_data(tx_data), .tx_hs(tx_hs), .tx_vs(tx_vs), .tx_de(tx_de)
  );

  int checks = 0;
  int fails  = 0;
  int starts = 0;
  bit done_flag = 0;
  logic exp_loop = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---- status scoreboard ----
  typedef struct {
    logic       lp;
    logic [2:0] idx;
    logic [3:0] ld;
    string      req;
  } st_t;
  st_t  st_q[$];
  event st_ev;

  task automatic expect_status(input logic lp, input logic [2:0] idx,
                               input logic [3:0] ld, input string req);
    st_t e;
    e.lp = lp; e.idx = idx; e.ld = ld; e.req = req;
    st_q.push_back(e);
    ->st_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(st_ev);
      while (st_q.size() > 0) begin
        st_t e;
        e = st_q.pop_front();
        check(loop_mode == e.lp, e.req, "loop_mode", loop_mode, e.lp);
        check(src_sel == e.lp, e.req, "src_sel", src_sel, e.lp);
        check(pattern_idx == e.idx, e.req, "pattern_idx", pattern_idx, e.idx);
        check(led == e.ld, e.req, "led", led, e.ld);
      end
    end
  end

  // ---- video scoreboard (R8) ----
  logic [PW+2:0] vid_q[$];

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (vid_q.size() > 0) begin
        logic [PW+2:0] exp_v;
        exp_v = vid_q.pop_front();
        check({tx_data, tx_hs, tx_vs, tx_de} == exp_v, "R8", "tx bundle",
              {tx_data, tx_hs, tx_vs, tx_de}, exp_v);
      end
    end
  end

  task automatic drive_video(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      gen_data = PW'($urandom); {gen_hs, gen_vs, gen_de} = 3'($urandom);
      rx_data  = PW'($urandom); {rx_hs, rx_vs, rx_de}    = 3'($urandom);
      vid_q.push_back(exp_loop ? {rx_data, rx_hs, rx_vs, rx_de}
                               : {gen_data, gen_hs, gen_vs, gen_de});
    end
    @(negedge clk);
  endtask

  // counts start pulses, one per high cycle
  always @(posedge clk) begin
    #1;
    if (edid_start) starts++;
  end

  task automatic set_btn(input int which, input logic v);
    case (which)
      0: btn_mode_n = v;
      1: btn_pattern_n = v;
      default: btn_edid_n = v;
    endcase
  endtask

  task automatic press_btn(input int which, input int hold);
    set_btn(which, 1'b0);
    repeat (hold) @(negedge clk);
    set_btn(which, 1'b1);
    repeat (40) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    btn_mode_n = 1; btn_pattern_n = 1; btn_edid_n = 1;
    edid_busy = 0; edid_done = 0; edid_fail = 0;
    gen_data = '0; gen_hs = 0; gen_vs = 0; gen_de = 0;
    rx_data = 24'h5a5a5a; rx_hs = 1; rx_vs = 1; rx_de = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    expect_status(1'b0, 3'd0, 4'b0000, "R3 R4 R6 reset");
    check(edid_start == 1'b0, "R9", "start after reset", edid_start, 0);
    check(tx_data == 24'h0, "R8", "tx_data after reset", tx_data, 0);

    // R1: glitches shorter than the debounce window
    for (int g = 0; g < 3; g++) begin
      set_btn(0, 1'b0); repeat (DB / 2) @(negedge clk);
      set_btn(0, 1'b1); repeat (4) @(negedge clk);
    end
    set_btn(1, 1'b0); repeat (DB - 4) @(negedge clk); set_btn(1, 1'b1);
    repeat (40) @(negedge clk);
    expect_status(1'b0, 3'd0, 4'b0000, "R1 glitch ignored");

    // R4/R6: step through formats and wrap
    for (int i = 1; i <= 5; i++) begin
      press_btn(1, 40);
      expect_status(1'b0, 3'(i), {1'b0, 3'(i)}, "R4 R6 advance");
    end
    press_btn(1, 40);
    expect_status(1'b0, 3'd0, 4'b0000, "R4 wrap 5 to 0");
    press_btn(1, 40);
    press_btn(1, 40);
    expect_status(1'b0, 3'd2, 4'b0010, "R4 R6 index 2");

    // R2/R3/R7: long hold acts once, on the press edge
    set_btn(0, 1'b0);
    repeat (40) @(negedge clk);
    expect_status(1'b1, 3'd2, 4'b1111, "R2 R3 R7 press edge");
    repeat (300) @(negedge clk);
    expect_status(1'b1, 3'd2, 4'b1111, "R2 held");
    set_btn(0, 1'b1);
    repeat (40) @(negedge clk);
    expect_status(1'b1, 3'd2, 4'b1111, "R2 release no action");
    exp_loop = 1'b1;

    // R5: format button ignored in loopback
    press_btn(1, 40);
    expect_status(1'b1, 3'd2, 4'b1111, "R5 ignored in loopback");

    // R8: loopback routing
    drive_video(20);

    // back to transmit
    press_btn(0, 40);
    exp_loop = 1'b0;
    expect_status(1'b0, 3'd2, 4'b0010, "R3 R6 back to transmit");
    drive_video(20);

    // R9/R10: rewrite start and blink phase
    set_btn(2, 1'b0);
    begin
      int w;
      w = 0;
      while (!edid_start && w < 200) begin
        @(negedge clk);
        w++;
      end
    end
    check(edid_start == 1'b1, "R9", "start issued", edid_start, 1);
    check(starts == 1, "R9", "start count", starts, 1);
    check(led == 4'b1111, "R10", "lit at start", led, 4'hf);
    @(negedge clk);
    check(edid_start == 1'b0, "R9", "start one cycle", edid_start, 0);
    edid_busy = 1'b1;
    repeat (HALF / 2 - 1) @(negedge clk);
    check(led == 4'b1111, "R10", "first lit phase", led, 4'hf);
    repeat (HALF) @(negedge clk);
    check(led == 4'b0000, "R10", "dark phase", led, 0);
    repeat (HALF) @(negedge clk);
    check(led == 4'b1111, "R10", "second lit phase", led, 4'hf);
    set_btn(2, 1'b1);
    repeat (40) @(negedge clk);

    // R12 and R9: presses during the rewrite
    press_btn(0, 40);
    press_btn(1, 40);
    check(loop_mode == 1'b0, "R12", "mode frozen", loop_mode, 0);
    check(pattern_idx == 3'd2, "R12", "index frozen", pattern_idx, 2);
    press_btn(2, 40);
    check(starts == 1, "R9", "no start while busy", starts, 1);

    // R11: failure ends the rewrite, retry works
    @(negedge clk);
    edid_fail = 1'b1; edid_busy = 1'b0;
    @(negedge clk);
    edid_fail = 1'b0;
    expect_status(1'b0, 3'd2, 4'b0010, "R11 after fail");
    press_btn(2, 40);
    check(starts == 2, "R11", "retry start", starts, 2);
    edid_busy = 1'b1;
    repeat (10) @(negedge clk);
    edid_done = 1'b1; edid_busy = 1'b0;
    @(negedge clk);
    edid_done = 1'b0;
    expect_status(1'b0, 3'd2, 4'b0010, "R11 after done");
    press_btn(1, 40);
    expect_status(1'b0, 3'd3, 4'b0011, "R11 controls restored");

    // R9: external busy blocks a start
    edid_busy = 1'b1;
    press_btn(2, 40);
    check(starts == 2, "R9", "busy writer blocks start", starts, 2);
    expect_status(1'b0, 3'd3, 4'b0011, "R9 no rewrite began");
    edid_busy = 1'b0;

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule